// File: doc/BRIEF.md
# PHY Control-Register Write Master

This block turns register-write requests into the four-phase parallel control-register handshake used by a set of PHY instances (two by default). A request names a PHY, a 16-bit register address and a 16-bit data word. The block loads that PHY's address and data outputs, waits one cycle, and then raises that PHY's write-enable. It waits for the PHY's acknowledge to go high, drops the write-enable, and then waits for the acknowledge to return low. Only then is the transfer complete. Each of the two wait phases has its own cycle budget. When a budget runs out, the block flags a warning, records the PHY in a sticky error bit and carries on with the sequence as if the acknowledge had arrived.

After reset, the block drives the interface-select line of every PHY high. It keeps every access back for a fixed settling interval. After that it accepts requests or a one-cycle start pulse for a built-in initialisation run. The run writes one fixed configuration word to four lane registers of each PHY in turn. The word enables CDR tracking, raises the loss-of-signal threshold, enables termination, sets the AC termination mode and enables the PHY.

Top module: `phycr_write_master`

## Requirements
- R1: While reset is held, all select lines, all write-enables, `req_ready`, `init_busy`, `tmo_pulse` and every `tmo_err` bit are 0.
- R2: All select lines are 1 from the first cycle after reset is released and stay 1. `req_ready` stays 0 for exactly SETTLE_CYC cycles of select high and rises in the cycle after that.
- R3: A PHY's address and data outputs carry the accepted request one cycle before its write-enable rises, and they do not change while the write-enable is high.
- R4: The write-enable drops in the cycle after the master samples acknowledge high. The transfer completes, with `req_ready` high again, in the cycle after the master samples acknowledge low. With an acknowledge that follows enable after d cycles, enable stays high d+1 cycles and completion comes d+1 cycles after enable drops.
- R5: `req_ready` is 0 from the cycle after acceptance until completion. Only the PHY given by `req_phy` sees a write-enable, and the other PHY's address output does not change.
- R6: If acknowledge is not high after TMO_CYC cycles of write-enable, the write-enable drops anyway. `tmo_pulse` is then high for one cycle, the PHY's `tmo_err` bit is set, and the low phase follows.
- R7: If acknowledge stays high for TMO_CYC cycles after write-enable drops, the transfer completes anyway, with the same one-cycle `tmo_pulse` and a set `tmo_err` bit for that PHY.
- R8: `tmo_err` bits (bit n = PHY n) remain set until reset, across later successful transfers.
- R9: A start pulse in the idle state runs eight writes: lanes 0 to 3 of PHY 0, then lanes 0 to 3 of PHY 1, to address 0x1008 + 0x100 × lane, each with data 0x0E21. `init_busy` is high and `req_ready` is 0 for the whole run.
- R10: A start pulse has priority over a request in the same cycle: `req_ready` is 0 in that cycle and the request is not performed. A start pulse that arrives while a transfer is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Master idle and able to take a request |
| req_phy | input | PW | Target PHY index |
| req_addr | input | 16 | Register address |
| req_data | input | 16 | Register write data |
| init_start | input | 1 | One-cycle start of the lane initialisation run |
| init_busy | output | 1 | Initialisation run in progress |
| phy_sel | output | NPHY | Interface-select line per PHY |
| phy_addr | output | NPHY×16 | Address per PHY, PHY n in bits [16n+15:16n] |
| phy_wdata | output | NPHY×16 | Write data per PHY, same packing |
| phy_wen | output | NPHY | Write-enable per PHY |
| phy_ack | input | NPHY | Acknowledge per PHY |
| tmo_pulse | output | 1 | One-cycle flag on any phase timeout |
| tmo_err | output | NPHY | Sticky timeout record per PHY |

## Verification
The bench builds the block with two PHYs, four lanes, a settling interval of 10 cycles and a timeout budget of 12 cycles instead of the default 500. The short budget makes both timeout phases and their sticky error bits quick to reach. The PHY model in the bench follows the write-enable with a delay of 1 to 3 cycles per PHY, or holds acknowledge stuck low or stuck high. The exact enable-high and enable-drop-to-ready cycle counts can therefore be predicted for each case and compared. The full eight-write initialisation run, with its priority over a same-cycle request and its immunity to a start pulse during a transfer, fits within a few hundred cycles.

// File: rtl/phycr_pkg.sv
package phycr_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;

    // lane register map used by the initialisation run
    localparam logic [ADDR_W-1:0] LANE_REG_BASE   = 16'h1008;
    localparam logic [ADDR_W-1:0] LANE_REG_STRIDE = 16'h0100;

    // bit positions of the lane configuration word
    localparam int BIT_CDR_TRACK = 0;
    localparam int BIT_LOS_LEVEL = 5;
    localparam int BIT_TERM_ON   = 9;
    localparam int BIT_TERM_AC   = 10;
    localparam int BIT_PHY_ON    = 11;

    localparam logic [DATA_W-1:0] LANE_CFG_WORD =
        (DATA_W'(1) << BIT_CDR_TRACK) | (DATA_W'(1) << BIT_LOS_LEVEL) |
        (DATA_W'(1) << BIT_TERM_ON)   | (DATA_W'(1) << BIT_TERM_AC)   |
        (DATA_W'(1) << BIT_PHY_ON);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } reg_wr_t;

    typedef enum logic [2:0] {
        HS_SETTLE,
        HS_IDLE,
        HS_SETUP,
        HS_WAIT_HI,
        HS_WAIT_LO
    } hs_state_e;

    function automatic logic [ADDR_W-1:0] lane_reg_addr(input int unsigned lane);
        return LANE_REG_BASE + ADDR_W'(LANE_REG_STRIDE * lane);
    endfunction

endpackage

// File: rtl/phycr_init_seq.sv
module phycr_init_seq
    import phycr_pkg::*;
#(
    parameter int NPHY   = 2,
    parameter int NLANES = 4,
    parameter int PW     = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          step_done,
    output logic          active,
    output logic          more,
    output logic [PW-1:0] nxt_phy,
    output reg_wr_t       nxt_wr
);
    localparam int STEPS = NPHY * NLANES;
    localparam int IW    = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [IW-1:0] LAST = IW'(STEPS - 1);

    logic [IW-1:0] idx_q;
    logic          active_q;
    logic [IW-1:0] pick;
    int unsigned   pick_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            idx_q    <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            idx_q    <= '0;
        end else if (step_done && active_q) begin
            if (idx_q == LAST) begin
                active_q <= 1'b0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    always_comb begin
        pick        = start ? '0 : idx_q + 1'b1;
        pick_i      = int'(pick);
        nxt_phy     = PW'(pick_i / NLANES);
        nxt_wr.addr = lane_reg_addr(pick_i % NLANES);
        nxt_wr.data = LANE_CFG_WORD;
    end

    assign active = active_q;
    assign more   = active_q && (idx_q != LAST);

endmodule

// File: rtl/phycr_hs_engine.sv
module phycr_hs_engine
    import phycr_pkg::*;
#(
    parameter int TMO_CYC    = 500,
    parameter int SETTLE_CYC = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic ack,
    output logic sel_on,
    output logic idle,
    output logic wen,
    output logic done,
    output logic tmo_evt
);
    localparam int CMAX = (TMO_CYC > SETTLE_CYC) ? TMO_CYC : SETTLE_CYC;
    localparam int CW   = $clog2(CMAX + 1);

    hs_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          wen_q, wen_d;
    logic          sel_q;
    logic          cnt_end;

    assign cnt_end = (cnt_q == CW'(TMO_CYC - 1));
    assign done    = (state_q == HS_WAIT_LO) && (!ack || cnt_end);
    assign tmo_evt = ((state_q == HS_WAIT_HI) && !ack && cnt_end) ||
                     ((state_q == HS_WAIT_LO) &&  ack && cnt_end);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        wen_d   = wen_q;
        unique case (state_q)
            HS_SETTLE: begin
                if (cnt_q == CW'(SETTLE_CYC)) begin
                    state_d = HS_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            HS_IDLE: begin
                if (load) state_d = HS_SETUP;
            end
            HS_SETUP: begin
                state_d = HS_WAIT_HI;
                wen_d   = 1'b1;
                cnt_d   = '0;
            end
            HS_WAIT_HI: begin
                if (ack || cnt_end) begin
                    state_d = HS_WAIT_LO;
                    wen_d   = 1'b0;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            HS_WAIT_LO: begin
                if (done) begin
                    state_d = load ? HS_SETUP : HS_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= HS_SETTLE;
            cnt_q   <= '0;
            wen_q   <= 1'b0;
            sel_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            wen_q   <= wen_d;
            sel_q   <= 1'b1;
        end
    end

    assign sel_on = sel_q;
    assign idle   = (state_q == HS_IDLE);
    assign wen    = wen_q;

endmodule

// File: rtl/phycr_phy_port.sv
module phycr_phy_port
    import phycr_pkg::*;
#(
    parameter int PHY_ID = 0,
    parameter int PW     = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [PW-1:0]     load_phy,
    input  reg_wr_t           load_wr,
    input  logic [PW-1:0]     cur_phy,
    input  logic              wen_any,
    input  logic              tmo_evt,
    input  logic              sel_on,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data,
    output logic              wen,
    output logic              sel,
    output logic              err
);
    localparam logic [PW-1:0] ME = PW'(PHY_ID);

    reg_wr_t wr_q;
    logic    err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            err_q <= 1'b0;
        end else begin
            if (load && (load_phy == ME)) wr_q <= load_wr;
            if (tmo_evt && (cur_phy == ME)) err_q <= 1'b1;
        end
    end

    assign addr = wr_q.addr;
    assign data = wr_q.data;
    assign wen  = wen_any && (cur_phy == ME);
    assign sel  = sel_on;
    assign err  = err_q;

endmodule

// File: rtl/phycr_write_master.sv
module phycr_write_master
    import phycr_pkg::*;
#(
    parameter int NPHY       = 2,
    parameter int NLANES     = 4,
    parameter int TMO_CYC    = 500,
    parameter int SETTLE_CYC = 10,
    parameter int PW         = (NPHY > 1) ? $clog2(NPHY) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [PW-1:0]          req_phy,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [DATA_W-1:0]      req_data,
    input  logic                   init_start,
    output logic                   init_busy,
    output logic [NPHY-1:0]        phy_sel,
    output logic [NPHY*ADDR_W-1:0] phy_addr,
    output logic [NPHY*DATA_W-1:0] phy_wdata,
    output logic [NPHY-1:0]        phy_wen,
    input  logic [NPHY-1:0]        phy_ack,
    output logic                   tmo_pulse,
    output logic [NPHY-1:0]        tmo_err
);
    logic          eng_idle, eng_wen, eng_done, eng_tmo, eng_sel;
    logic          seq_more, seq_active, seq_start;
    logic [PW-1:0] seq_phy;
    reg_wr_t       seq_wr;

    logic          take_user, load;
    logic [PW-1:0] load_phy;
    reg_wr_t       load_wr;
    logic [PW-1:0] cur_phy_q;
    logic          ack_cur;
    logic          tmo_pulse_q;

    assign take_user = eng_idle && !init_start;
    assign seq_start = eng_idle && init_start;
    assign load      = (take_user && req_valid) || seq_start || (eng_done && seq_more);
    assign load_phy  = take_user ? req_phy : seq_phy;
    assign load_wr   = take_user ? reg_wr_t'{addr: req_addr, data: req_data} : seq_wr;
    assign ack_cur   = phy_ack[cur_phy_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_phy_q   <= '0;
            tmo_pulse_q <= 1'b0;
        end else begin
            if (load) cur_phy_q <= load_phy;
            tmo_pulse_q <= eng_tmo;
        end
    end

    phycr_hs_engine #(
        .TMO_CYC    (TMO_CYC),
        .SETTLE_CYC (SETTLE_CYC)
    ) u_engine (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .ack     (ack_cur),
        .sel_on  (eng_sel),
        .idle    (eng_idle),
        .wen     (eng_wen),
        .done    (eng_done),
        .tmo_evt (eng_tmo)
    );

    phycr_init_seq #(
        .NPHY   (NPHY),
        .NLANES (NLANES),
        .PW     (PW)
    ) u_init (
        .clk       (clk),
        .rst       (rst),
        .start     (seq_start),
        .step_done (eng_done),
        .active    (seq_active),
        .more      (seq_more),
        .nxt_phy   (seq_phy),
        .nxt_wr    (seq_wr)
    );

    for (genvar g = 0; g < NPHY; g++) begin : g_port
        phycr_phy_port #(
            .PHY_ID (g),
            .PW     (PW)
        ) u_port (
            .clk      (clk),
            .rst      (rst),
            .load     (load),
            .load_phy (load_phy),
            .load_wr  (load_wr),
            .cur_phy  (cur_phy_q),
            .wen_any  (eng_wen),
            .tmo_evt  (eng_tmo),
            .sel_on   (eng_sel),
            .addr     (phy_addr[g*ADDR_W +: ADDR_W]),
            .data     (phy_wdata[g*DATA_W +: DATA_W]),
            .wen      (phy_wen[g]),
            .sel      (phy_sel[g]),
            .err      (tmo_err[g])
        );
    end

    assign req_ready = take_user;
    assign init_busy = seq_active;
    assign tmo_pulse = tmo_pulse_q;

endmodule

// File: rtl/phycr_write_master_chk.sv
module phycr_write_master_chk #(
    parameter int NPHY       = 2,
    parameter int SETTLE_CYC = 10
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_ready,
    input logic                 init_busy,
    input logic [NPHY-1:0]      phy_sel,
    input logic [NPHY*16-1:0]   phy_addr,
    input logic [NPHY*16-1:0]   phy_wdata,
    input logic [NPHY-1:0]      phy_wen,
    input logic [NPHY-1:0]      phy_ack,
    input logic                 tmo_pulse,
    input logic [NPHY-1:0]      tmo_err
);
    logic [15:0] sel_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_cnt <= '0;
        end else if ((&phy_sel) && (sel_cnt != 16'hFFFF)) begin
            sel_cnt <= sel_cnt + 16'd1;
        end
    end

    AST_SEL_KEPT: assert property (@(posedge clk) disable iff (rst)
        (&phy_sel) |=> (&phy_sel)); // R2

    AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (sel_cnt >= 16'(SETTLE_CYC))); // R2

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        (|phy_wen) |-> !req_ready); // R5

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
        $onehot0(phy_wen)); // R5

    AST_INIT_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        init_busy |-> !req_ready); // R9

    for (genvar g = 0; g < NPHY; g++) begin : g_chk
        AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
            (phy_wen[g] && $past(phy_wen[g])) |->
            ($stable(phy_addr[g*16 +: 16]) && $stable(phy_wdata[g*16 +: 16]))); // R3

        AST_WEN_DROP_CAUSE: assert property (@(posedge clk) disable iff (rst)
            $fell(phy_wen[g]) |-> ($past(phy_ack[g]) || tmo_pulse)); // R4

        AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
            tmo_err[g] |=> tmo_err[g]); // R8
    end

endmodule

bind phycr_write_master phycr_write_master_chk #(
    .NPHY       (NPHY),
    .SETTLE_CYC (SETTLE_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .init_busy (init_busy),
    .phy_sel   (phy_sel),
    .phy_addr  (phy_addr),
    .phy_wdata (phy_wdata),
    .phy_wen   (phy_wen),
    .phy_ack   (phy_ack),
    .tmo_pulse (tmo_pulse),
    .tmo_err   (tmo_err)
);

// File: tb/phycr_write_master_tb_top.sv
module phycr_write_master_tb_top;

    localparam int NPHY   = 2;
    localparam int NLANES = 4;
    localparam int TMO    = 12;
    localparam int SETTLE = 10;
    localparam int PW     = 1;

    typedef struct packed {
        logic        phy;
        logic [15:0] addr;
        logic [15:0] data;
        logic [1:0]  dly;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 16'h0010, 16'hA5A5, 2'd1},
        '{1'b1, 16'h1234, 16'h5A5A, 2'd1},
        '{1'b0, 16'hFFFF, 16'h0000, 2'd2},
        '{1'b1, 16'h0000, 16'hFFFF, 2'd3},
        '{1'b0, 16'h8001, 16'h0E21, 2'd3},
        '{1'b1, 16'h7FFE, 16'h1357, 2'd2}
    };

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                rst;
    logic                req_valid;
    logic                req_ready;
    logic [PW-1:0]       req_phy;
    logic [15:0]         req_addr;
    logic [15:0]         req_data;
    logic                init_start;
    logic                init_busy;
    logic [NPHY-1:0]     phy_sel;
    logic [NPHY*16-1:0]  phy_addr;
    logic [NPHY*16-1:0]  phy_wdata;
    logic [NPHY-1:0]     phy_wen;
    logic [NPHY-1:0]     phy_ack;
    logic                tmo_pulse;
    logic [NPHY-1:0]     tmo_err;

    phycr_write_master #(
        .NPHY       (NPHY),
        .NLANES     (NLANES),
        .TMO_CYC    (TMO),
        .SETTLE_CYC (SETTLE)
    ) dut_i (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_phy    (req_phy),
        .req_addr   (req_addr),
        .req_data   (req_data),
        .init_start (init_start),
        .init_busy  (init_busy),
        .phy_sel    (phy_sel),
        .phy_addr   (phy_addr),
        .phy_wdata  (phy_wdata),
        .phy_wen    (phy_wen),
        .phy_ack    (phy_ack),
        .tmo_pulse  (tmo_pulse),
        .tmo_err    (tmo_err)
    );

    int n_chk  = 0;
    int n_fail = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // PHY model: acknowledge follows write-enable after dly cycles, or is stuck
    logic [3:0] hist [NPHY];
    int         dly  [NPHY];
    int         mode [NPHY];   // 0 follow, 1 stuck low, 2 stuck high

    initial begin
        for (int p = 0; p < NPHY; p++) begin
            hist[p] = '0;
            dly[p]  = 1;
            mode[p] = 0;
        end
    end

    always @(posedge clk) begin
        for (int p = 0; p < NPHY; p++) hist[p] <= {hist[p][2:0], phy_wen[p]};
    end

    always @* begin
        for (int p = 0; p < NPHY; p++) begin
            if (mode[p] == 1)      phy_ack[p] = 1'b0;
            else if (mode[p] == 2) phy_ack[p] = 1'b1;
            else                   phy_ack[p] = hist[p][dly[p]-1];
        end
    end

    // write monitor: logs each write-enable rise, checks address setup
    logic [NPHY-1:0] wen_prev = '0;
    logic [15:0]     addr_prev [NPHY];
    int              log_n = 0;
    int              log_phy  [32];
    logic [15:0]     log_addr [32];
    logic [15:0]     log_data [32];

    always @(negedge clk) begin
        for (int p = 0; p < NPHY; p++) begin
            if (phy_wen[p] && !wen_prev[p]) begin
                chk("R3 address presented before enable", 32'(addr_prev[p]), 32'(phy_addr[p*16 +: 16]));
                if (log_n < 32) begin
                    log_phy[log_n]  = p;
                    log_addr[log_n] = phy_addr[p*16 +: 16];
                    log_data[log_n] = phy_wdata[p*16 +: 16];
                end
                log_n++;
            end
            wen_prev[p]  = phy_wen[p];
            addr_prev[p] = phy_addr[p*16 +: 16];
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<100000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic do_write(input int p, input logic [15:0] a, input logic [15:0] d,
                            output int hi, output int lo, output int tp, output int ow);
        @(negedge clk);
        req_valid = 1'b1;
        req_phy   = PW'(p);
        req_addr  = a;
        req_data  = d;
        @(negedge clk);
        req_valid = 1'b0;
        hi = 0; lo = 0; tp = 0; ow = 0;
        for (int k = 0; k < 1000; k++) begin
            if (tmo_pulse) tp++;
            if (req_ready) break;
            if (phy_wen[p]) hi++;
            else if (hi > 0) lo++;
            if (phy_wen[1-p]) ow++;
            @(negedge clk);
        end
    endtask

    initial begin
        int hi, lo, tp, ow, cnt, bad, busy_seen, start_n;
        logic [15:0] other_addr;
        rst = 1'b1; req_valid = 1'b0; req_phy = '0; req_addr = '0;
        req_data = '0; init_start = 1'b0;

        // reset state
        repeat (3) @(negedge clk);
        chk("R1 select in reset", 32'(phy_sel), 32'h0);
        chk("R1 enable in reset", 32'(phy_wen), 32'h0);
        chk("R1 ready in reset", 32'(req_ready), 32'h0);
        chk("R1 flags in reset", {28'h0, tmo_err, tmo_pulse, init_busy}, 32'h0);

        // select and settle
        rst = 1'b0;
        @(negedge clk);
        chk("R2 select after reset", 32'(phy_sel), 32'h3);
        cnt = 0;
        for (int k = 0; k < 100; k++) begin
            if (req_ready) break;
            if (phy_sel == 2'b11) cnt++;
            @(negedge clk);
        end
        chk("R2 settle cycles", 32'(cnt), 32'(SETTLE));

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            dly[VEC[i].phy] = int'(VEC[i].dly);
            start_n    = log_n;
            other_addr = phy_addr[(1-int'(VEC[i].phy))*16 +: 16];
            do_write(int'(VEC[i].phy), VEC[i].addr, VEC[i].data, hi, lo, tp, ow);
            chk("R4 enable high cycles", 32'(hi), 32'(VEC[i].dly) + 32'd1);
            chk("R4 drop to completion cycles", 32'(lo), 32'(VEC[i].dly) + 32'd1);
            chk("R5 other PHY enable", 32'(ow), 32'h0);
            chk("R5 other PHY address", 32'(phy_addr[(1-int'(VEC[i].phy))*16 +: 16]), 32'(other_addr));
            chk("R3 one write logged", 32'(log_n - start_n), 32'h1);
            chk("R3 logged PHY", 32'(log_phy[start_n]), 32'(VEC[i].phy));
            chk("R3 logged address", 32'(log_addr[start_n]), 32'(VEC[i].addr));
            chk("R3 logged data", 32'(log_data[start_n]), 32'(VEC[i].data));
            chk("R6 no spurious timeout", {30'h0, tmo_err} | 32'(tp), 32'h0);
        end

        // timeout in the high phase on PHY 1
        mode[1] = 1;
        do_write(1, 16'h0042, 16'h0001, hi, lo, tp, ow);
        chk("R6 enable high until budget", 32'(hi), 32'(TMO));
        chk("R6 low phase after timeout", 32'(lo), 32'h1);
        chk("R6 single timeout pulse", 32'(tp), 32'h1);
        chk("R6 error bit of PHY 1", 32'(tmo_err), 32'h2);
        mode[1] = 0;

        // later success keeps the error
        dly[0] = 1;
        do_write(0, 16'h0043, 16'h0002, hi, lo, tp, ow);
        chk("R8 error kept after success", 32'(tmo_err), 32'h2);

        // timeout in the low phase on PHY 0
        mode[0] = 2;
        do_write(0, 16'h0044, 16'h0003, hi, lo, tp, ow);
        chk("R7 enable drops on ack", 32'(hi), 32'h1);
        chk("R7 low phase until budget", 32'(lo), 32'(TMO));
        chk("R7 single timeout pulse", 32'(tp), 32'h1);
        chk("R7 error bits both PHYs", 32'(tmo_err), 32'h3);
        mode[0] = 0;
        repeat (4) @(negedge clk);

        // initialisation run with a same-cycle request
        dly[0] = 2; dly[1] = 1;
        start_n    = log_n;
        init_start = 1'b1;
        req_valid  = 1'b1;
        req_phy    = '0;
        req_addr   = 16'hBEEF;
        req_data   = 16'h1111;
        #1;
        chk("R10 ready low under start", 32'(req_ready), 32'h0);
        @(negedge clk);
        init_start = 1'b0;
        req_valid  = 1'b0;
        chk("R9 busy after start", 32'(init_busy), 32'h1);
        bad = 0;
        for (int k = 0; k < 2000; k++) begin
            if (!init_busy) break;
            if (req_ready) bad++;
            @(negedge clk);
        end
        chk("R9 ready low during run", 32'(bad), 32'h0);
        chk("R9 eight writes, request dropped", 32'(log_n - start_n), 32'h8);
        for (int i = 0; i < 8; i++) begin
            chk("R9 run PHY order", 32'(log_phy[start_n+i]), 32'(i / NLANES));
            chk("R9 run lane address", 32'(log_addr[start_n+i]), 32'h1008 + 32'h100 * 32'(i % NLANES));
            chk("R9 run data word", 32'(log_data[start_n+i]), 32'h0E21);
        end
        chk("R9 ready after run", 32'(req_ready), 32'h1);

        // start pulse during a transfer is ignored
        dly[0] = 3;
        start_n = log_n;
        busy_seen = 0;
        @(negedge clk);
        req_valid = 1'b1; req_phy = '0; req_addr = 16'h0100; req_data = 16'h0200;
        @(negedge clk);
        req_valid  = 1'b0;
        init_start = 1'b1;
        @(negedge clk);
        init_start = 1'b0;
        for (int k = 0; k < 200; k++) begin
            if (init_busy) busy_seen++;
            if (req_ready) break;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
        chk("R10 start ignored while busy", 32'(busy_seen), 32'h0);
        chk("R10 only the request performed", 32'(log_n - start_n), 32'h1);

        // reset clears the sticky bits
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8 errors cleared by reset", 32'(tmo_err), 32'h0);
        chk("R1 select low in reset", 32'(phy_sel), 32'h0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule